// File: doc/BRIEF.md
# Byte-Wide PROM Boot Loader

This block boots a programmable device from an external memory. It reads the memory one byte at a time, or, in a serial variant, takes a bit stream directly. While reset is held it latches a 3-bit mode code. The code selects one of three operating styles: bit-serial input with no address, byte-wide reading with the address counting up from zero, or byte-wide reading with the address counting down from the top of an 18-bit space.

The block makes its own configuration clock by dividing the system clock. It drives this clock out so that downstream devices can follow it. On each rising edge of that clock it emits one configuration bit together with a one-cycle valid strobe. Bytes are sent most significant bit first.

Configuration always starts at the slow rate. If a chosen bit position in the opening part of the stream carries a one, the clock moves to the fast rate at the next byte boundary. A done input freezes everything and parks the clock low.

Top module: `prom_boot_loader`

## Requirements
- R1: The mode code is taken while rst_n is low (the value present at the last reset edge counts). Changes to mode_code after reset is released have no effect on addressing or on the stream.
- R2: Mode code 3'b000 selects serial input, 3'b100 selects counting up, and 3'b110 selects counting down. Any other code leaves the block idle: cfg_clk stays low and bit_valid never rises.
- R3: In count-up mode the first byte is read at address 0x00000. The address then rises by one after each byte has been fully shifted out.
- R4: In count-down mode the address is 0x3FFFF from reset onward. It then falls by one after each byte has been fully shifted out.
- R5: cfg_clk is low during reset. bit_valid is a pulse one system cycle long. It is raised only in the cycle where cfg_clk goes high, and one bit is emitted per rising edge.
- R6: Each byte read from the memory is emitted on bit_out most significant bit first.
- R7: After reset, each half period of cfg_clk lasts SLOW_HALF system cycles, so bit_valid pulses are 2*SLOW_HALF cycles apart.
- R8: The stream bit at 0-based position SPEED_BIT_POS (counted from the first bit after reset) is the speed request. If it is 1, every bit after the end of the byte that holds it is spaced 2*FAST_HALF cycles apart, and the rate never falls back. If it is 0, the rate stays slow.
- R9: In serial mode, bit_out is serial_din as sampled at each cfg_clk rising edge, and prom_addr stays at zero.
- R10: While done is high, cfg_clk is low from the next cycle on, no bit_valid pulse occurs, and prom_addr does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_code | input | 3 | Mode selection, latched during reset |
| done | input | 1 | Stops the clock and addressing while high |
| prom_data | input | 8 | Byte read from the memory at prom_addr |
| serial_din | input | 1 | Serial configuration input used in serial mode |
| prom_addr | output | 18 | Memory address of the byte being read |
| cfg_clk | output | 1 | Generated configuration clock |
| bit_out | output | 1 | Serial configuration bit |
| bit_valid | output | 1 | One-cycle strobe marking a new bit_out |

## Verification
The assertions assume two things about the inputs. First, prom_data settles to the byte at prom_addr within a cfg_clk period after the address moves. Second, serial_din holds steady around each rising edge of cfg_clk. The bench models the memory as a combinational function of prom_addr, so data follows the address in the same cycle. In serial mode it changes serial_din only in the falling half of the system clock, just after observing a valid strobe, and that leaves the value stable for several cycles before the next rising edge. The done and mode inputs are likewise driven only between clock edges.

// File: rtl/boot_loader_pkg.sv
// Shared definitions for the byte-wide PROM boot loader.
// Assumes: mode codes are 3 bits wide and decoded once at reset.
package boot_loader_pkg;

    typedef enum logic [1:0] {
        LOAD_IDLE   = 2'd0,
        LOAD_SERIAL = 2'd1,
        LOAD_UP     = 2'd2,
        LOAD_DOWN   = 2'd3
    } load_mode_t;

    // Map the external 3-bit code to an operating style.
    function automatic load_mode_t decode_mode(input logic [2:0] code);
        case (code)
            3'b000:  decode_mode = LOAD_SERIAL;
            3'b100:  decode_mode = LOAD_UP;
            3'b110:  decode_mode = LOAD_DOWN;
            default: decode_mode = LOAD_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/cfg_clock_gen.sv
// Divides the system clock into the configuration clock.
// Each half period lasts SLOW_HALF or FAST_HALF system cycles, chosen by
// fast_sel. rise_tick marks the system cycle in which cfg_clk goes high.
// Assumes: both half-period values are at least 1.
module cfg_clock_gen #(
    parameter int SLOW_HALF = 16,
    parameter int FAST_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hold,
    input  logic fast_sel,
    output logic cfg_clk,
    output logic rise_tick
);
    localparam int MAX_HALF = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int CNT_W    = $clog2(MAX_HALF + 1);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_HALF - 1);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_HALF - 1);

    logic [CNT_W-1:0] half_cnt;
    logic             clk_q;
    logic             wrap;

    // Half-period end detection; >= covers a switch to a shorter period.
    always_comb begin
        wrap      = half_cnt >= (fast_sel ? FAST_LAST : SLOW_LAST);
        rise_tick = run && !hold && wrap && !clk_q;
    end

    // Count system cycles and toggle the output clock at each half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_cnt <= '0;
            clk_q    <= 1'b0;
        end else if (hold || !run) begin
            half_cnt <= '0;
            clk_q    <= 1'b0;
        end else if (wrap) begin
            half_cnt <= '0;
            clk_q    <= ~clk_q;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    assign cfg_clk = clk_q;

    assert_hold_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !cfg_clk);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !cfg_clk);
    assert_tick_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> cfg_clk);

endmodule

// File: rtl/prom_addr_gen.sv
// Produces the memory address. During reset it loads the start value for the
// selected mode. Afterwards it steps once per completed byte: up, down, or
// not at all.
// Assumes: mode_sel is steady once reset has been released.
module prom_addr_gen
    import boot_loader_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  load_mode_t        mode_sel,
    input  logic              step,
    input  logic              hold,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    // Load the start address in reset, then step on each finished byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= (mode_sel == LOAD_DOWN) ? TOP_ADDR : '0;
        end else if (step && !hold) begin
            case (mode_sel)
                LOAD_UP:   addr <= addr + 1'b1;
                LOAD_DOWN: addr <= addr - 1'b1;
                default:   addr <= addr;
            endcase
        end
    end

    assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hold && mode_sel == LOAD_UP) |=> addr == $past(addr) + 1'b1);
    assert_down_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hold && mode_sel == LOAD_DOWN) |=> addr == $past(addr) - 1'b1);
    assert_serial_noaddr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == LOAD_SERIAL) |=> addr == '0);
    assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(addr));

endmodule

// File: rtl/cfg_bit_shifter.sv
// Sends one bit per configuration clock rising edge, either from the memory
// byte (MSB first) or straight from the serial input. It also watches for
// the speed request bit and raises fast_sel at the next byte boundary.
// Assumes: prom_byte is valid when the first bit of a byte is taken.
module cfg_bit_shifter #(
    parameter int SPEED_BIT_POS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_tick,
    input  logic       serial_mode,
    input  logic [7:0] prom_byte,
    input  logic       serial_bit,
    output logic       bit_out,
    output logic       bit_valid,
    output logic       byte_done,
    output logic       fast_sel
);
    localparam int POS_W = $clog2(SPEED_BIT_POS + 2);
    localparam logic [POS_W-1:0] REQ_POS = POS_W'(SPEED_BIT_POS);
    localparam logic [POS_W-1:0] SAT_POS = POS_W'(SPEED_BIT_POS + 1);

    logic [2:0]       bit_idx;
    logic [6:0]       shreg;
    logic [POS_W-1:0] bit_cnt;
    logic             req_pend;
    logic             next_bit;
    logic             req_hit;

    // Choose the next outgoing bit and spot the speed request.
    always_comb begin
        if (serial_mode)
            next_bit = serial_bit;
        else if (bit_idx == 3'd0)
            next_bit = prom_byte[7];
        else
            next_bit = shreg[6];
        req_hit   = (bit_cnt == REQ_POS) && next_bit;
        byte_done = rise_tick && (bit_idx == 3'd7);
    end

    // Shift bits out and keep the in-byte position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx   <= 3'd0;
            shreg     <= '0;
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
        end else if (rise_tick) begin
            bit_out   <= next_bit;
            bit_valid <= 1'b1;
            bit_idx   <= bit_idx + 1'b1;
            shreg     <= (bit_idx == 3'd0) ? prom_byte[6:0] : {shreg[5:0], 1'b0};
        end else begin
            bit_valid <= 1'b0;
        end
    end

    // Track the stream position and raise the fast rate at a byte boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            req_pend <= 1'b0;
            fast_sel <= 1'b0;
        end else if (rise_tick) begin
            if (bit_cnt != SAT_POS)
                bit_cnt <= bit_cnt + 1'b1;
            if (req_hit)
                req_pend <= 1'b1;
            if (byte_done && (req_pend || req_hit))
                fast_sel <= 1'b1;
        end
    end

    assert_fast_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fast_sel |=> fast_sel);
    assert_switch_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_sel && !byte_done) |=> !fast_sel);
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

endmodule

// File: rtl/prom_boot_loader.sv
// Top level of the byte-wide PROM boot loader. It latches the mode during
// reset and wires together the clock divider, the address generator and the
// bit shifter.
// Assumes: mode_code is settled while rst_n is low, and prom_data follows
// prom_addr within one configuration clock period.
module prom_boot_loader
    import boot_loader_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int SLOW_HALF     = 16,
    parameter int FAST_HALF     = 2,
    parameter int SPEED_BIT_POS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_code,
    input  logic              done,
    input  logic [7:0]        prom_data,
    input  logic              serial_din,
    output logic [ADDR_W-1:0] prom_addr,
    output logic              cfg_clk,
    output logic              bit_out,
    output logic              bit_valid
);
    load_mode_t mode_q;
    load_mode_t mode_sel;
    logic       run;
    logic       rise_tick;
    logic       byte_done;
    logic       fast_sel;

    // Latch the decoded mode while reset is held; keep it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= decode_mode(mode_code);
    end

    // During reset the address start follows the live code.
    always_comb begin
        mode_sel = rst_n ? mode_q : decode_mode(mode_code);
        run      = (mode_q != LOAD_IDLE);
    end

    cfg_clock_gen #(
        .SLOW_HALF (SLOW_HALF),
        .FAST_HALF (FAST_HALF)
    ) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .hold      (done),
        .fast_sel  (fast_sel),
        .cfg_clk   (cfg_clk),
        .rise_tick (rise_tick)
    );

    prom_addr_gen #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .step     (byte_done),
        .hold     (done),
        .addr     (prom_addr)
    );

    cfg_bit_shifter #(
        .SPEED_BIT_POS (SPEED_BIT_POS)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_tick   (rise_tick),
        .serial_mode (mode_q == LOAD_SERIAL),
        .prom_byte   (prom_data),
        .serial_bit  (serial_din),
        .bit_out     (bit_out),
        .bit_valid   (bit_valid),
        .byte_done   (byte_done),
        .fast_sel    (fast_sel)
    );

    assert_mode_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mode_q));
    assert_valid_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (cfg_clk && $rose(cfg_clk)));
    assert_no_valid_when_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !bit_valid);

endmodule

// File: tb/prom_boot_loader_test.sv
// Directed bench for the PROM boot loader: one task per scenario.
module prom_boot_loader_test;
    localparam int SLOW = 16;
    localparam int FAST = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_code = 3'b100;
    logic        done = 1'b0;
    logic [7:0]  prom_data;
    logic        serial_din = 1'b0;
    logic [17:0] prom_addr;
    logic        cfg_clk;
    logic        bit_out;
    logic        bit_valid;

    logic [17:0] first_addr = 18'h0;
    logic [7:0]  first_val  = 8'hF7;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic bits [0:63];
    int   tq   [0:63];
    logic [15:0] ser_pat = 16'h0;
    bit          ser_on  = 1'b0;

    prom_boot_loader uut (
        .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .done(done),
        .prom_data(prom_data), .serial_din(serial_din), .prom_addr(prom_addr),
        .cfg_clk(cfg_clk), .bit_out(bit_out), .bit_valid(bit_valid)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] mem_fn(input logic [17:0] a);
        return a[7:0] ^ 8'hC3 ^ a[17:10];
    endfunction

    assign prom_data = (prom_addr == first_addr) ? first_val : mem_fn(prom_addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] code);
        @(negedge clk);
        rst_n = 1'b0;
        done = 1'b0;
        mode_code = code;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic collect(input int n);
        int got = 0;
        int lim = 0;
        while (got < n && lim < 4000) begin
            @(negedge clk);
            lim++;
            if (bit_valid) begin
                bits[got] = bit_out;
                tq[got] = cyc;
                got++;
                if (ser_on && got < 16) serial_din = ser_pat[15-got];
            end
        end
        chk(got == n, "R5", "bits collected", got, n);
    endtask

    function automatic logic [7:0] byte_at(input int k);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7-i] = bits[8*k+i];
        return b;
    endfunction

    task automatic test_reset();
        first_addr = 18'h0;
        @(negedge clk);
        rst_n = 1'b0;
        mode_code = 3'b100;
        repeat (3) @(negedge clk);
        chk(cfg_clk == 1'b0, "R5", "cfg_clk in reset", cfg_clk, 0);
        chk(bit_valid == 1'b0, "R5", "valid in reset", bit_valid, 0);
        chk(prom_addr == 18'h0, "R3", "up start addr", prom_addr, 0);
        mode_code = 3'b110;
        @(negedge clk);
        chk(prom_addr == 18'h3FFFF, "R4", "down start addr", prom_addr, 18'h3FFFF);
    endtask

    task automatic test_up();
        first_addr = 18'h0;
        first_val = 8'hF7;
        do_reset(3'b100);
        mode_code = 3'b110;  // ignored after reset (R1)
        collect(24);
        chk(byte_at(0) == 8'hF7, "R6", "up byte0", byte_at(0), 8'hF7);
        chk(byte_at(1) == mem_fn(18'd1), "R3", "up byte1", byte_at(1), mem_fn(18'd1));
        chk(byte_at(2) == mem_fn(18'd2), "R1", "up byte2 after code change", byte_at(2), mem_fn(18'd2));
        chk(prom_addr == 18'd3, "R3", "addr after 3 bytes", prom_addr, 3);
        chk(tq[1] - tq[0] == 2 * SLOW, "R7", "slow spacing", tq[1] - tq[0], 2 * SLOW);
        chk(tq[20] - tq[19] == 2 * SLOW, "R8", "no switch with bit 0", tq[20] - tq[19], 2 * SLOW);
    endtask

    task automatic test_down();
        first_addr = 18'h3FFFF;
        first_val = 8'hF7;
        do_reset(3'b110);
        collect(16);
        chk(byte_at(0) == 8'hF7, "R4", "down byte0", byte_at(0), 8'hF7);
        chk(byte_at(1) == mem_fn(18'h3FFFE), "R4", "down byte1", byte_at(1), mem_fn(18'h3FFFE));
        chk(prom_addr == 18'h3FFFD, "R4", "down addr", prom_addr, 18'h3FFFD);
    endtask

    task automatic test_fast();
        first_addr = 18'h0;
        first_val = 8'h08;  // stream position 4 is byte bit 3
        do_reset(3'b100);
        collect(24);
        chk(byte_at(0) == 8'h08, "R6", "fast byte0", byte_at(0), 8'h08);
        chk(byte_at(2) == mem_fn(18'd2), "R8", "fast byte2", byte_at(2), mem_fn(18'd2));
        chk(tq[7] - tq[6] == 2 * SLOW, "R8", "slow until boundary", tq[7] - tq[6], 2 * SLOW);
        chk(tq[8] - tq[7] == 2 * FAST, "R8", "fast after boundary", tq[8] - tq[7], 2 * FAST);
        chk(tq[23] - tq[22] == 2 * FAST, "R8", "fast stays", tq[23] - tq[22], 2 * FAST);
    endtask

    task automatic test_serial();
        logic [15:0] got;
        first_addr = 18'h0;
        ser_pat = 16'hA35C;
        ser_on = 1'b1;
        serial_din = ser_pat[15];
        do_reset(3'b000);
        collect(16);
        ser_on = 1'b0;
        for (int i = 0; i < 16; i++) got[15-i] = bits[i];
        chk(got == 16'hA35C, "R9", "serial stream", got, 16'hA35C);
        chk(prom_addr == 18'h0, "R9", "serial addr", prom_addr, 0);
        chk(tq[12] - tq[11] == 2 * SLOW, "R2", "serial rate", tq[12] - tq[11], 2 * SLOW);
    endtask

    task automatic test_bad_mode();
        int v = 0;
        int hi = 0;
        do_reset(3'b010);
        repeat (200) begin
            @(negedge clk);
            if (bit_valid) v++;
            if (cfg_clk) hi++;
        end
        chk(v == 0, "R2", "idle code valids", v, 0);
        chk(hi == 0, "R2", "idle code clock", hi, 0);
    endtask

    task automatic test_done();
        logic [17:0] a0;
        int v = 0;
        int hi = 0;
        first_addr = 18'h0;
        first_val = 8'hF7;
        do_reset(3'b100);
        collect(10);
        done = 1'b1;
        a0 = prom_addr;
        chk(a0 == 18'd1, "R3", "addr after 10 bits", a0, 1);
        repeat (100) begin
            @(negedge clk);
            if (bit_valid) v++;
            if (cfg_clk) hi++;
        end
        chk(hi == 0, "R10", "clock low on done", hi, 0);
        chk(v == 0, "R10", "no valid on done", v, 0);
        chk(prom_addr == a0, "R10", "addr frozen", prom_addr, a0);
        done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_reset();
        test_up();
        test_down();
        test_fast();
        test_serial();
        test_bad_mode();
        test_done();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule